// File: doc/BRIEF.md
# Display AUX Transaction Sequencer

This block carries out a single request on a display AUX side channel for a host. The host gives a 4-bit command type, a 20-bit target address, a byte count from 1 to 16 and up to 16 bytes of write data, then pulses `start`. The sequencer first waits for any earlier transaction on the channel to drain. It then asks for ownership of the channel through a request/grant pair and confirms that a sink is attached. Only after these steps does it drive a lower-level engine. That engine handles the line coding and is seen here only as reset/start/done/status.

Each attempt on the engine begins with a one-cycle engine reset. An attempt that ends with any error-status bit set is repeated after a settle delay, up to a fixed number of attempts. An engine that never answers ends the whole transaction with an error. All waits are counted in pulses of a microsecond tick input. At the end the block releases ownership, raises `done` for one cycle and reports a 2-bit result. For a read that succeeds, it also returns the engine's 16-byte read buffer.

Top module: `aux_xact_seq`

## Requirements
- R1: If `chan_active` stays high for IDLE_US ticks after `start`, the transaction ends with result 1 (busy), without raising `own_req` or touching the engine.
- R2: Once the channel is idle, `own_req` rises. If `own_gnt` does not arrive within GRANT_US ticks, the result is 1 (busy) and `own_req` is dropped.
- R3: With ownership granted and `sink_present` low, the result is 2 (no device) and `eng_start` never pulses.
- R4: During an attempt, `eng_cmd` equals the command type, `eng_addr` equals the address, and `eng_len` equals byte count minus one in 4 bits.
- R5: Command bit 0 selects read (1) or write (0). Only a write loads `wr_data` into `eng_wdata`. Only a read that ends with result 0 loads `rd_data` from `eng_rdata`. In every other case both hold their earlier contents.
- R6: Every `eng_start` is preceded by an `eng_reset` pulse for that attempt. Every attempt after the first is preceded by at least GAP_US ticks.
- R7: If `eng_done` does not arrive within REQ_US ticks of `eng_start`, the transaction ends with result 3 (remote error) and no further attempt is made.
- R8: An attempt succeeds, with result 0 (ok), when `eng_done` comes with `eng_status` all zero. A nonzero status causes a retry, up to MAX_TRIES attempts in all; after that the result is 3.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after `start` until `done`. `own_req` is low in the cycle after `done` for every outcome.
- R10: After reset, `busy`, `done`, `own_req`, `eng_reset` and `eng_start` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cmd | input | 4 | Command type; bit 0 = read |
| addr | input | 20 | Target address |
| byte_count | input | 5 | Bytes to transfer, 1 to 16 |
| wr_data | input | 128 | Write bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 busy, 2 no device, 3 remote error |
| rd_data | output | 128 | Read buffer returned to host |
| chan_active | input | 1 | An earlier transaction still occupies the channel |
| own_req | output | 1 | Ownership request |
| own_gnt | input | 1 | Ownership grant |
| sink_present | input | 1 | Sink detected |
| eng_reset | output | 1 | Engine reset pulse |
| eng_start | output | 1 | Engine request pulse |
| eng_cmd | output | 4 | Command to engine |
| eng_addr | output | 20 | Address to engine |
| eng_len | output | 4 | Byte count minus one |
| eng_wdata | output | 128 | Write buffer to engine |
| eng_done | input | 1 | Engine attempt complete |
| eng_status | input | 8 | Two 4-bit error groups |
| eng_rdata | input | 128 | Engine read buffer |

## Verification
The bench builds the block with IDLE_US, GRANT_US and REQ_US set to 12, GAP_US set to 5 and MAX_TRIES set to 6, and drives a tick every four cycles. With these small values, every timeout fires within a few hundred cycles. The retry limit can be exhausted, so the boundary between a success on the last attempt and a remote error after all attempts is exercised. The retry gap can also be measured between consecutive engine requests.

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter int IDLE_US   = 1000,
  parameter int GRANT_US  = 1000,
  parameter int REQ_US    = 1000,
  parameter int GAP_US    = 400,
  parameter int MAX_TRIES = 32,
  parameter int ADDR_W    = 20,
  parameter int BUF_BYTES = 16,
  parameter int STAT_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   us_tick,
  input  logic                   start,
  input  logic [3:0]             cmd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [$clog2(BUF_BYTES):0] byte_count,
  input  logic [BUF_BYTES*8-1:0] wr_data,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             result,
  output logic [BUF_BYTES*8-1:0] rd_data,
  input  logic                   chan_active,
  output logic                   own_req,
  input  logic                   own_gnt,
  input  logic                   sink_present,
  output logic                   eng_reset,
  output logic                   eng_start,
  output logic [3:0]             eng_cmd,
  output logic [ADDR_W-1:0]      eng_addr,
  output logic [$clog2(BUF_BYTES)-1:0] eng_len,
  output logic [BUF_BYTES*8-1:0] eng_wdata,
  input  logic                   eng_done,
  input  logic [STAT_W-1:0]      eng_status,
  input  logic [BUF_BYTES*8-1:0] eng_rdata
);
  localparam int BUF_W = BUF_BYTES * 8;
  localparam int LEN_W = $clog2(BUF_BYTES);
  localparam int CNT_W = LEN_W + 1;
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam int T_A   = (IDLE_US > GRANT_US) ? IDLE_US : GRANT_US;
  localparam int T_B   = (REQ_US > GAP_US) ? REQ_US : GAP_US;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int T_W   = $clog2(T_MAX + 1);

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_BUSY   = 2'd1;
  localparam logic [1:0] RES_NODEV  = 2'd2;
  localparam logic [1:0] RES_REMOTE = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WIDLE, ST_WGNT, ST_SINK, ST_RST, ST_GAP, ST_REQ, ST_WDONE, ST_FIN
  } state_t;

  state_t            state_q;
  logic [T_W-1:0]    timer_q;
  logic [TRY_W-1:0]  tries_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [BUF_W-1:0]  wbuf_q;
  logic [BUF_W-1:0]  rbuf_q;
  logic [1:0]        res_q;

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign result    = res_q;
  assign rd_data   = rbuf_q;
  assign own_req   = (state_q == ST_WGNT) || (state_q == ST_SINK) || (state_q == ST_RST) ||
                     (state_q == ST_GAP)  || (state_q == ST_REQ)  || (state_q == ST_WDONE);
  assign eng_reset = (state_q == ST_RST);
  assign eng_start = (state_q == ST_REQ);
  assign eng_cmd   = cmd_q;
  assign eng_addr  = addr_q;
  assign eng_len   = len_q;
  assign eng_wdata = wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      tries_q <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      res_q   <= RES_OK;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          cmd_q   <= cmd;
          addr_q  <= addr;
          len_q   <= LEN_W'(byte_count - CNT_W'(1));
          if (!cmd[0]) wbuf_q <= wr_data;
          tries_q <= '0;
          timer_q <= '0;
          state_q <= ST_WIDLE;
        end
        ST_WIDLE: begin
          if (!chan_active) begin
            timer_q <= '0;
            state_q <= ST_WGNT;
          end else if (us_tick) begin
            if (timer_q == T_W'(IDLE_US - 1)) begin
              res_q   <= RES_BUSY;
              state_q <= ST_FIN;
            end else timer_q <= timer_q + 1'b1;
          end
        end
        ST_WGNT: begin
          if (own_gnt) state_q <= ST_SINK;
          else if (us_tick) begin
            if (timer_q == T_W'(GRANT_US - 1)) begin
              res_q   <= RES_BUSY;
              state_q <= ST_FIN;
            end else timer_q <= timer_q + 1'b1;
          end
        end
        ST_SINK: begin
          if (!sink_present) begin
            res_q   <= RES_NODEV;
            state_q <= ST_FIN;
          end else state_q <= ST_RST;
        end
        ST_RST: begin
          timer_q <= '0;
          state_q <= (tries_q == '0) ? ST_REQ : ST_GAP;
        end
        ST_GAP: if (us_tick) begin
          if (timer_q == T_W'(GAP_US - 1)) state_q <= ST_REQ;
          else timer_q <= timer_q + 1'b1;
        end
        ST_REQ: begin
          timer_q <= '0;
          state_q <= ST_WDONE;
        end
        ST_WDONE: begin
          if (eng_done) begin
            if (eng_status == '0) begin
              res_q <= RES_OK;
              if (cmd_q[0]) rbuf_q <= eng_rdata;
              state_q <= ST_FIN;
            end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
              res_q   <= RES_REMOTE;
              state_q <= ST_FIN;
            end else begin
              tries_q <= tries_q + 1'b1;
              state_q <= ST_RST;
            end
          end else if (us_tick) begin
            if (timer_q == T_W'(REQ_US - 1)) begin
              res_q   <= RES_REMOTE;
              state_q <= ST_FIN;
            end else timer_q <= timer_q + 1'b1;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_nodev_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SINK && !sink_present) |=> (done && result == RES_NODEV && !eng_start));

  assert_retry_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && tries_q != '0) |-> $past(state_q == ST_GAP));

  assert_ok_needs_clean_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> $past(eng_done && eng_status == '0));

  assert_tries_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(MAX_TRIES - 1));

  assert_release_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !own_req);

  assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK && eng_cmd[0]) |-> rd_data == $past(eng_rdata));
endmodule

// File: tb/sim_aux_xact_seq.sv
module sim_aux_xact_seq;
  localparam int IDLE_US = 12, GRANT_US = 12, REQ_US = 12, GAP_US = 5, MAX_TRIES = 6;

  logic clk = 0, rst_n = 0, us_tick = 0, start = 0;
  logic [3:0] cmd = 0;
  logic [19:0] addr = 0;
  logic [4:0] byte_count = 1;
  logic [127:0] wr_data = 0;
  logic busy, done, own_req, eng_reset, eng_start;
  logic [1:0] result;
  logic [127:0] rd_data, eng_wdata;
  logic [3:0] eng_cmd, eng_len;
  logic [19:0] eng_addr;
  logic own_gnt = 0, sink_present = 1, eng_done = 0;
  logic [7:0] eng_status = 0;
  logic [127:0] eng_rdata = 0;
  logic chan_active;

  aux_xact_seq #(.IDLE_US(IDLE_US), .GRANT_US(GRANT_US), .REQ_US(REQ_US),
                 .GAP_US(GAP_US), .MAX_TRIES(MAX_TRIES)) u0 (
    .clk, .rst_n, .us_tick, .start, .cmd, .addr, .byte_count, .wr_data,
    .busy, .done, .result, .rd_data, .chan_active, .own_req, .own_gnt,
    .sink_present, .eng_reset, .eng_start, .eng_cmd, .eng_addr, .eng_len,
    .eng_wdata, .eng_done, .eng_status, .eng_rdata);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [1:0] div = 0;
  int tick_cnt = 0;
  always @(posedge clk) begin
    div <= div + 1'b1;
    us_tick <= (div == 2'd3);
  end

  // scenario knobs
  int chan_hold = 0;
  bit gnt_never = 0, no_reply = 0;
  int fails = 0, gnt_delay = 2;
  // monitor state
  int chan_left = 0;
  int attempts = 0, order_viol = 0, req_rises = 0, min_gap = 1 << 30, last_start_tick = 0;
  bit reset_seen = 0, own_q = 0;
  int lat = -1, gcnt = 0;
  logic [3:0] cap_cmd; logic [19:0] cap_addr; logic [3:0] cap_len; logic [127:0] cap_wdata;
  logic [127:0] ok_rdata = 0;

  assign chan_active = (chan_left != 0);

  always @(posedge clk) begin
    if (us_tick) tick_cnt <= tick_cnt + 1;
    if (start) chan_left <= chan_hold;
    else if (us_tick && chan_left != 0 && chan_left != 65535) chan_left <= chan_left - 1;
    own_q <= own_req;
    if (own_req && !own_q) req_rises <= req_rises + 1;
    if (!own_req) begin own_gnt <= 0; gcnt <= 0; end
    else if (!gnt_never) begin
      if (gcnt == gnt_delay) own_gnt <= 1; else gcnt <= gcnt + 1;
    end
    eng_done <= 0;
    if (eng_reset) begin reset_seen <= 1; lat <= -1; end
    if (eng_start) begin
      if (!reset_seen) order_viol <= order_viol + 1;
      reset_seen <= 0;
      if (attempts > 0 && tick_cnt - last_start_tick < min_gap) min_gap <= tick_cnt - last_start_tick;
      last_start_tick <= tick_cnt;
      attempts <= attempts + 1;
      cap_cmd <= eng_cmd; cap_addr <= eng_addr; cap_len <= eng_len; cap_wdata <= eng_wdata;
      lat <= 3;
    end else if (lat > 0) lat <= lat - 1;
    else if (lat == 0) begin
      lat <= -1;
      if (!no_reply) begin
        eng_done <= 1;
        eng_status <= (attempts <= fails) ? ((attempts % 2 == 1) ? 8'h10 : 8'h02) : 8'h00;
        eng_rdata <= {$urandom, $urandom, $urandom, $urandom};
      end
    end
  end

  always @(posedge clk) if (eng_done && eng_status == 0) ok_rdata <= eng_rdata;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_result(int hold, bit gn, bit sk, int f, bit nr);
    if (hold >= IDLE_US) return 2'd1;
    if (gn) return 2'd1;
    if (!sk) return 2'd2;
    if (nr) return 2'd3;
    if (f >= MAX_TRIES) return 2'd3;
    return 2'd0;
  endfunction

  function automatic int exp_attempts(int hold, bit gn, bit sk, int f, bit nr);
    if (hold >= IDLE_US || gn || !sk) return 0;
    if (nr) return 1;
    return (f + 1 < MAX_TRIES) ? f + 1 : MAX_TRIES;
  endfunction

  logic [127:0] last_wr = 0;

  task automatic run(input logic [3:0] c, input logic [19:0] a, input int n, input logic [127:0] wd);
    logic [1:0] er; int ea, guard; logic [127:0] prev_rd, exp_rd;
    er = exp_result(chan_hold, gnt_never, sink_present, fails, no_reply);
    ea = exp_attempts(chan_hold, gnt_never, sink_present, fails, no_reply);
    prev_rd = rd_data;
    @(negedge clk);
    attempts = 0; order_viol = 0; req_rises = 0; min_gap = 1 << 30;
    cmd = c; addr = a; byte_count = 5'(n); wr_data = wd; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R9 busy after start", busy, 1);
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(result == er, "R1/R2/R3/R7/R8 result", result, er);
    chk(attempts == ea, "R8 attempt count", attempts, ea);
    chk(order_viol == 0, "R6 reset before start", order_viol, 0);
    if (chan_hold >= IDLE_US) chk(req_rises == 0, "R1 no own_req while channel busy", req_rises, 0);
    if (ea > 1) chk(min_gap >= GAP_US, "R6 retry gap ticks", min_gap, GAP_US);
    if (ea > 0) begin
      chk(cap_cmd == c && cap_addr == a, "R4 cmd/addr", {cap_cmd, cap_addr}, {c, a});
      chk(cap_len == 4'(n - 1), "R4 length", cap_len, 4'(n - 1));
      chk(cap_wdata == (c[0] ? last_wr : wd), "R5 write buffer", cap_wdata, c[0] ? last_wr : wd);
    end
    if (!c[0]) last_wr = wd;
    exp_rd = (c[0] && er == 2'd0) ? ok_rdata : prev_rd;
    chk(rd_data == exp_rd, "R5 read buffer", rd_data, exp_rd);
    @(negedge clk);
    chk(!done && !own_req && !busy, "R9 release after done", {done, own_req, busy}, 0);
    chk(eng_wdata == last_wr, "R5 engine write buffer held", eng_wdata, last_wr);
    chan_hold = 0; gnt_never = 0; no_reply = 0; fails = 0; sink_present = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !own_req && !eng_reset && !eng_start && result == 0, "R10 reset state",
        {busy, done, own_req, eng_reset, eng_start, result}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run(4'h8, 20'h00100, 2, 128'h0000_BEEF);
    fails = 0; run(4'h9, 20'h00202, 6, 128'h1);
    chan_hold = 3; run(4'h9, 20'h00000, 4, 128'h2);
    chan_hold = 65535; run(4'h8, 20'h12345, 1, 128'h3);
    gnt_never = 1; run(4'h8, 20'hABCDE, 16, 128'h4);
    gnt_delay = 6; run(4'h8, 20'h0000A, 16, {4{32'hCAFE_F00D}});
    gnt_delay = 2;
    sink_present = 0; run(4'h9, 20'h00001, 3, 128'h5);
    no_reply = 1; run(4'h9, 20'h00002, 8, 128'h6);
    fails = MAX_TRIES - 1; run(4'h9, 20'h00003, 6, 128'h7);
    fails = MAX_TRIES; run(4'h9, 20'h00004, 6, 128'h8);
    fails = 2; run(4'h8, 20'hFFFFF, 16, {4{32'h0123_4567}});
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [3:0] c; int n; int r;
      c = 4'($urandom_range(15, 0));
      n = $urandom_range(16, 1);
      r = $urandom_range(15, 0);
      fails = $urandom_range(MAX_TRIES + 1, 0);
      if (r == 0) sink_present = 0;
      else if (r == 1) chan_hold = 65535;
      else if (r == 2) gnt_never = 1;
      else if (r == 3) no_reply = 1;
      else if (r < 7) chan_hold = $urandom_range(IDLE_US - 4, 1);
      gnt_delay = $urandom_range(8, 0);
      run(c, 20'($urandom), n, {$urandom, $urandom, $urandom, $urandom});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule